// File: doc/BRIEF.md
# Single-Wire Discovery Acknowledge Responder

This block is the device-side front end of a single-wire, open-drain bus. It watches a synchronized copy of the line level and recognises a bus reset when the master holds the line low long enough. During normal operation that threshold is the reset time. While the device reports itself busy, the threshold is the much longer discharge time, so a busy operation can only be aborted by a long low. Each bus reset clears the external address pointer and returns the device to high-speed mode. Synchronous power-up reset has the same effect.

After a bus reset the responder waits for the line to stay high for a recovery interval. It then treats the next falling level as the master's discovery request. It answers by driving the line low, one clock after it samples the request. It keeps driving for a fixed acknowledge interval, which outlasts the master's own pulse. Once it releases the line and the line has stayed high for a setup interval, it raises a ready flag. From that point the command layer may run. A request from that layer to drop to standard speed is honoured only while the block is ready.

All intervals are counted in clock cycles and set by parameters. The command decoder and the memory are outside this block.

Top module: `swi_discovery_responder`

## Requirements
- R1: While `rst` is high, `ptr_clear` and `high_speed` read 1, and `ready` and `drive_low` read 0.
- R2: With `busy` low, a low line held for RESET_CYC consecutive sampled cycles raises `ptr_clear` for exactly one cycle. The pulse appears in the cycle after the RESET_CYC-th low sample. A shorter low raises no pulse and leaves `ready` unchanged.
- R3: With `busy` high, a bus reset needs DSCHG_CYC consecutive low samples. Lows of RESET_CYC up to DSCHG_CYC-1 samples leave `ptr_clear` low and `ready` high.
- R4: A bus reset drops `ready` in the same cycle as the `ptr_clear` pulse and sets `high_speed` to 1. One unbroken low yields only one pulse, however long it lasts.
- R5: After a bus reset, a low that arrives before the line has been high for RRT_CYC consecutive samples is not acknowledged. Such a low also restarts the recovery count.
- R6: Once recovered, the first low sample raises `drive_low` in the next cycle. `drive_low` then stays high for exactly DACK_CYC cycles, even if the master releases the line earlier.
- R7: After `drive_low` falls, `ready` rises once the line has been sampled high for HTSS_CYC consecutive cycles. It becomes visible in the cycle after the HTSS_CYC-th high sample.
- R8: `std_speed_req` clears `high_speed` in the next cycle only while `ready` is 1. Otherwise it has no effect.
- R9: While `ready` is 1, lows on the line are never answered with `drive_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| line_lvl | input | 1 | Synchronized bus line level, 1 = high |
| busy | input | 1 | Device is executing an operation |
| std_speed_req | input | 1 | Command layer asks for standard speed |
| drive_low | output | 1 | Enable for the open-drain pull-down |
| ptr_clear | output | 1 | Clear the address pointer |
| high_speed | output | 1 | 1 = high-speed mode, 0 = standard speed |
| ready | output | 1 | Discovery complete, start condition may follow |

## Verification
The embedded properties check, on every cycle, several structural rules:
- an acknowledge can only begin from the armed phase on a sampled low;
- `ready` rises only from the setup phase after a high sample;
- the pull-down is never active while ready;
- every `ptr_clear` pulse comes out of a low line and leaves the device in high-speed mode, unready;
- the speed flag falls only on an accepted request.

The exact threshold arithmetic can only be shown by the bench's sweeps. These cover the low length against the idle and busy thresholds, the recovery count against early pulses, and the exact acknowledge and setup lengths.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [2:0] {
    PH_RECOVER = 3'd0,
    PH_ARMED   = 3'd1,
    PH_ACK     = 3'd2,
    PH_SETUP   = 3'd3,
    PH_READY   = 3'd4
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swd_low_watch.sv
module swd_low_watch #(
  parameter int RESET_CYC = 480,
  parameter int DSCHG_CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic line_lvl,
  input  logic busy,
  input  logic hold_off,
  output logic bus_rst
);
  localparam int CW = $clog2(DSCHG_CYC + 1);
  localparam logic [CW-1:0] IDLE_LIM = CW'(RESET_CYC - 1);
  localparam logic [CW-1:0] BUSY_LIM = CW'(DSCHG_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic [CW-1:0] lim;
  logic          fired;
  logic          counting;

  // the line is not counted while this device itself pulls it low
  assign counting = !line_lvl && !hold_off;
  assign lim      = busy ? BUSY_LIM : IDLE_LIM;
  assign bus_rst  = counting && !fired && (low_cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      fired   <= 1'b0;
    end else if (!counting) begin
      low_cnt <= '0;
      fired   <= 1'b0;
    end else begin
      if (low_cnt < BUSY_LIM) low_cnt <= low_cnt + 1'b1;
      if (bus_rst) fired <= 1'b1;
    end
  end

  // R4: one unbroken low produces a single reset event
  assert_single_event_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> !bus_rst);

endmodule

// File: rtl/swd_phase_ctl.sv
module swd_phase_ctl
  import swd_pkg::*;
#(
  parameter int RRT_CYC  = 80,
  parameter int DACK_CYC = 40,
  parameter int HTSS_CYC = 150
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   line_lvl,
  input  logic   bus_rst,
  output phase_e phase,
  output logic   drive_low,
  output logic   ready
);
  localparam int MAXC = max3(RRT_CYC, DACK_CYC, HTSS_CYC);
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] RRT_LIM  = PW'(RRT_CYC - 1);
  localparam logic [PW-1:0] DACK_LIM = PW'(DACK_CYC - 1);
  localparam logic [PW-1:0] HTSS_LIM = PW'(HTSS_CYC - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      phase     <= PH_RECOVER;
      cnt       <= '0;
      drive_low <= 1'b0;
      ready     <= 1'b0;
    end else begin
      case (phase)
        PH_RECOVER: begin
          if (!line_lvl) begin
            cnt <= '0;
          end else if (cnt == RRT_LIM) begin
            phase <= PH_ARMED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ARMED: begin
          if (!line_lvl) begin
            phase     <= PH_ACK;
            drive_low <= 1'b1;
            cnt       <= '0;
          end
        end
        PH_ACK: begin
          if (cnt == DACK_LIM) begin
            phase     <= PH_SETUP;
            drive_low <= 1'b0;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SETUP: begin
          if (!line_lvl) begin
            cnt <= '0;
          end else if (cnt == HTSS_LIM) begin
            phase <= PH_READY;
            ready <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_READY: begin
          cnt <= '0;
        end
        default: begin
          phase     <= PH_RECOVER;
          cnt       <= '0;
          drive_low <= 1'b0;
          ready     <= 1'b0;
        end
      endcase
    end
  end

  // R5: an acknowledge only starts from the armed phase on a sampled low
  assert_ack_from_armed_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> ($past(phase) == PH_ARMED) && !$past(line_lvl));

  // R6: the acknowledge counter never runs past its limit
  assert_ack_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACK) |-> (cnt <= DACK_LIM) && drive_low);

  // R7: ready comes only out of setup after a high sample
  assert_ready_after_high_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(phase) == PH_SETUP) && $past(line_lvl));

  // R9: no pull-down while ready
  assert_quiet_when_ready_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> !drive_low);

endmodule

// File: rtl/swd_dev_state.sv
module swd_dev_state (
  input  logic clk,
  input  logic rst,
  input  logic bus_rst,
  input  logic ready,
  input  logic std_speed_req,
  output logic ptr_clear,
  output logic high_speed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_clear  <= 1'b1;
      high_speed <= 1'b1;
    end else begin
      ptr_clear <= bus_rst;
      if (bus_rst)                     high_speed <= 1'b1;
      else if (ready && std_speed_req) high_speed <= 1'b0;
    end
  end

  // R8: the speed flag only falls on a request accepted while ready
  assert_speed_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(high_speed) |-> $past(ready) && $past(std_speed_req));

endmodule

// File: rtl/swi_discovery_responder.sv
module swi_discovery_responder
  import swd_pkg::*;
#(
  parameter int RESET_CYC = 480,
  parameter int DSCHG_CYC = 1500,
  parameter int RRT_CYC   = 80,
  parameter int DACK_CYC  = 40,
  parameter int HTSS_CYC  = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic line_lvl,
  input  logic busy,
  input  logic std_speed_req,
  output logic drive_low,
  output logic ptr_clear,
  output logic high_speed,
  output logic ready
);
  phase_e phase;
  logic   bus_rst;
  logic   in_ack;

  assign in_ack = (phase == PH_ACK);

  swd_low_watch #(
    .RESET_CYC (RESET_CYC),
    .DSCHG_CYC (DSCHG_CYC)
  ) u_low_watch (
    .clk      (clk),
    .rst      (rst),
    .line_lvl (line_lvl),
    .busy     (busy),
    .hold_off (in_ack),
    .bus_rst  (bus_rst)
  );

  swd_phase_ctl #(
    .RRT_CYC  (RRT_CYC),
    .DACK_CYC (DACK_CYC),
    .HTSS_CYC (HTSS_CYC)
  ) u_phase_ctl (
    .clk       (clk),
    .rst       (rst),
    .line_lvl  (line_lvl),
    .bus_rst   (bus_rst),
    .phase     (phase),
    .drive_low (drive_low),
    .ready     (ready)
  );

  swd_dev_state u_dev_state (
    .clk           (clk),
    .rst           (rst),
    .bus_rst       (bus_rst),
    .ready         (ready),
    .std_speed_req (std_speed_req),
    .ptr_clear     (ptr_clear),
    .high_speed    (high_speed)
  );

  // R2: a pointer clear pulse is always caused by a low line
  assert_clear_from_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ptr_clear) |-> !$past(line_lvl));

  // R4: a bus reset leaves the device unready and in high-speed mode
  assert_clear_state_R4: assert property (@(posedge clk) disable iff (rst)
    ptr_clear |-> high_speed && !ready && !drive_low);

endmodule

// File: tb/swi_discovery_responder_tb.sv
module swi_discovery_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_C  = 8;
  localparam int DSC_C  = 20;
  localparam int RRT_C  = 4;
  localparam int DACK_C = 6;
  localparam int HTSS_C = 3;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst, busy, std_speed_req, m_low;
  logic line_lvl, drive_low, ptr_clear, high_speed, ready;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_lvl = !(m_low || drive_low);

  swi_discovery_responder #(
    .RESET_CYC (RST_C),
    .DSCHG_CYC (DSC_C),
    .RRT_CYC   (RRT_C),
    .DACK_CYC  (DACK_C),
    .HTSS_CYC  (HTSS_C)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .line_lvl      (line_lvl),
    .busy          (busy),
    .std_speed_req (std_speed_req),
    .drive_low     (drive_low),
    .ptr_clear     (ptr_clear),
    .high_speed    (high_speed),
    .ready         (ready)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // long idle low, leaves the line released and the block recovering
  task automatic bus_reset();
    m_low = 1'b1;
    cyc_n(RST_C + 1);
    m_low = 1'b0;
  endtask

  // recovery, discovery pulse, acknowledge and setup (R6, R7)
  task automatic discover();
    int n;
    cyc_n(RRT_C);
    m_low = 1'b1;
    @(negedge clk);
    n = 0;
    while (drive_low && n < 100) begin
      n++;
      if (n == 2) m_low = 1'b0;
      @(negedge clk);
    end
    m_low = 1'b0;
    chk(n == DACK_C, "R6 acknowledge length", n, DACK_C);
    chk(ready == 1'b0, "R7 ready before setup", int'(ready), 0);
    for (int k = 1; k <= HTSS_C; k++) begin
      @(negedge clk);
      chk(ready == (k == HTSS_C), "R7 ready timing", int'(ready), int'(k == HTSS_C));
    end
  endtask

  // hold a low of len samples from the ready state (R2, R3, R4, R9)
  task automatic low_probe(input int len, input int thr, input string req);
    int pulses, first_at;
    logic acked;
    logic exp_rst;
    pulses = 0; first_at = 0; acked = 1'b0;
    exp_rst = (len >= thr);
    m_low = 1'b1;
    for (int i = 1; i <= len + 2; i++) begin
      if (i == len + 1) m_low = 1'b0;
      @(negedge clk);
      if (ptr_clear) begin
        pulses++;
        if (first_at == 0) first_at = i;
        chk(!ready && high_speed, "R4 state at clear", int'(ready), 0);
      end
      if (drive_low) acked = 1'b1;
    end
    chk(pulses == int'(exp_rst), req, pulses, int'(exp_rst));
    if (exp_rst) chk(first_at == thr, req, first_at, thr);
    chk(ready == !exp_rst, req, int'(ready), int'(!exp_rst));
    chk(!acked, "R9 no acknowledge while ready", int'(acked), 0);
  endtask

  initial begin
    rst = 1'b1; busy = 1'b0; std_speed_req = 1'b0; m_low = 1'b0;
    cyc_n(3);
    chk(ptr_clear == 1'b1,  "R1 ptr_clear in reset",  int'(ptr_clear), 1);
    chk(high_speed == 1'b1, "R1 high_speed in reset", int'(high_speed), 1);
    chk(ready == 1'b0,      "R1 ready in reset",      int'(ready), 0);
    chk(drive_low == 1'b0,  "R1 drive_low in reset",  int'(drive_low), 0);
    rst = 1'b0;

    // first discovery after a bus reset; speed request ignored while not ready
    bus_reset();
    std_speed_req = 1'b1;
    @(negedge clk);
    std_speed_req = 1'b0;
    chk(high_speed == 1'b1, "R8 request ignored before ready", int'(high_speed), 1);
    discover();
    std_speed_req = 1'b1;
    @(negedge clk);
    std_speed_req = 1'b0;
    chk(high_speed == 1'b0, "R8 request accepted when ready", int'(high_speed), 0);
    bus_reset();
    chk(high_speed == 1'b1, "R4 reset restores high speed", int'(high_speed), 1);
    chk(ready == 1'b0, "R4 reset drops ready", int'(ready), 0);

    // idle threshold sweep (R2)
    for (int len = 1; len <= RST_C + 2; len++) begin
      bus_reset();
      discover();
      low_probe(len, RST_C, "R2 idle reset threshold");
    end

    // busy threshold sweep (R3)
    for (int len = RST_C; len <= DSC_C + 1; len++) begin
      bus_reset();
      discover();
      busy = 1'b1;
      low_probe(len, DSC_C, "R3 busy discharge threshold");
      busy = 1'b0;
    end

    // recovery window sweep (R5)
    for (int k = 1; k <= RRT_C + 1; k++) begin
      bus_reset();
      cyc_n(k);
      m_low = 1'b1;
      @(negedge clk);
      m_low = 1'b0;
      chk(drive_low == (k >= RRT_C), "R5 early pulse not acknowledged",
          int'(drive_low), int'(k >= RRT_C));
      if (k >= RRT_C) begin
        while (drive_low) @(negedge clk);
        cyc_n(HTSS_C);
        chk(ready == 1'b1, "R7 ready after late pulse", int'(ready), 1);
      end else begin
        cyc_n(RRT_C - 1);
        m_low = 1'b1;
        @(negedge clk);
        m_low = 1'b0;
        chk(drive_low == 1'b0, "R5 recovery count restarted", int'(drive_low), 0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule